// File: doc/BRIEF.md
# Power-Up Reset Time-Out Sequencer

This block keeps a processor core in reset after a power-on pulse, a brown-out event or a wake from sleep, and releases it only once the supply and the oscillator have had time to settle. It runs two timers in cascade. The first is a power-up delay measured in ticks of a slow timebase. The second is an oscillator start-up count of oscillator clock cycles. The selected oscillator mode and the power-up timer enable decide which of the two timers run.

The power-on pulse resets the whole block asynchronously, and the sequence starts when that pulse ends. The external active-low reset pin goes through a two-stage synchroniser. It only gates the final release, so the timers keep counting while the pin is held low. If the pin stays low past both timers, raising it lets the core run after the synchroniser delay alone. A brown-out restarts the full power-up sequence. A wake-up skips the power-up delay.

The sequencer state comes out as a debug output with this encoding: 0 idle, 1 power-up delay, 2 oscillator start-up, 3 holding for the pin, 4 running. The oscillator mode input is encoded as 0 LP, 1 XT, 2 HS and 3 RC. LP, XT and HS are the crystal-type modes.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is 1, `run_en` is 0 and `seq_state` is 0 (idle).
- R2: After `por_pulse` falls in a crystal-type mode (0, 1 or 2) with `pwrt_en`=1 and `slow_tick` held high, `run_en` rises on clock edge 1+PWRT_TICKS+OST_CYCLES.
- R3: After power-on in a crystal-type mode with `pwrt_en`=0, `run_en` rises on edge 1+OST_CYCLES, or on edge 3 if that is later, because of the pin synchroniser.
- R4: In RC mode (3) the oscillator start-up count never runs. Power-on with `pwrt_en`=1 releases on edge 1+PWRT_TICKS, and with `pwrt_en`=0 it releases on edge 3.
- R5: The power-up delay counter advances only on cycles where `slow_tick` is 1. While `slow_tick` is low the state stays at 1.
- R6: A one-cycle `wake_evt` in the running state moves the sequencer to idle and skips the power-up delay. Counting the wake edge as edge 1, `run_en` rises on edge 2+OST_CYCLES in a crystal-type mode and on edge 2 in RC mode.
- R7: A `bor_evt` in any state moves the sequencer to idle on the next edge and starts the full power-up sequence again. From running with XT mode and `pwrt_en`=1, `run_en` rises on edge 2+PWRT_TICKS+OST_CYCLES, counting the event edge as edge 1.
- R8: `osc_mode` and `pwrt_en` are sampled only when a sequence starts. Changing them part way through has no effect on the release time.
- R9: If `ext_rst_n` is low when the timers finish, the state holds at 3 with `core_rst` high. After the pin rises, `run_en` is still 0 after two edges and is 1 after the third.
- R10: When `ext_rst_n` falls in the running state, `core_rst` is asserted on the third edge and the state is 3, not idle. After the pin rises, `run_en` returns on the third edge with no time-out.
- R11: `run_en` is 1 exactly when `seq_state` is 4, and `core_rst` is always the inverse of `run_en`.
- R12: `wake_evt` outside the running state is ignored and does not change the release time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_pulse | input | 1 | Power-on reset pulse, active high, asynchronous |
| bor_evt | input | 1 | Brown-out event, one cycle, synchronous |
| wake_evt | input | 1 | Wake-from-sleep event, one cycle, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| slow_tick | input | 1 | Timebase tick for the power-up delay |
| osc_mode | input | 2 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 RC |
| pwrt_en | input | 1 | Power-up delay enable |
| core_rst | output | 1 | Internal core reset, active high |
| run_en | output | 1 | Core run enable |
| seq_state | output | 3 | Sequencer state, debug |

## Verification
Every result is due at a cycle count fixed by the timers and the registers along the path. For a power-on, the edge after the pulse ends is edge 1, and each timer adds its full terminal count. A wake or brown-out adds one edge for the visit to idle, and a pin change adds three edges: two synchroniser flops and the state register. The bench drives inputs and samples outputs on falling clock edges, counts rising edges until `run_en` rises, and compares that count with the value computed from these rules. Where a release must not happen early, it also checks the output one edge before it is due.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PWRUP   = 3'd1,
        ST_OSCST   = 3'd2,
        ST_PINHOLD = 3'd3,
        ST_RUN     = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        OSC_LP = 2'd0,
        OSC_XT = 2'd1,
        OSC_HS = 2'd2,
        OSC_RC = 2'd3
    } osc_mode_e;

    typedef enum logic {
        KIND_POWER = 1'b0,
        KIND_WAKE  = 1'b1
    } start_kind_e;

    typedef struct packed {
        seq_state_e  st;
        start_kind_e kind;
        logic        xtal;
    } seq_regs_t;

    function automatic logic mode_needs_ost(input logic [1:0] mode);
        return mode != OSC_RC;
    endfunction

endpackage

// File: rtl/rts_sync.sv
module rts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/rts_timer.sv
module rts_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic step,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TERM = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && step && (cnt_q == TERM);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (done) cnt_d = '0;
        else if (step) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
    import rts_pkg::*;
#(
    parameter int PWRT_TICKS  = 72,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_osc,
    input  logic       por_pulse,
    input  logic       bor_evt,
    input  logic       wake_evt,
    input  logic       ext_rst_n,
    input  logic       slow_tick,
    input  logic [1:0] osc_mode,
    input  logic       pwrt_en,
    output logic       core_rst,
    output logic       run_en,
    output logic [2:0] seq_state
);
    seq_regs_t  cur_q, cur_d;
    logic       pin_ok;
    logic       pwr_done, ost_done;
    logic       cfg_xtal;
    seq_state_e finish_st;

    rts_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk      (clk_osc),
        .rst      (por_pulse),
        .async_in (ext_rst_n),
        .sync_out (pin_ok)
    );

    rts_timer #(.LIMIT(PWRT_TICKS)) u_pwr_timer (
        .clk  (clk_osc),
        .rst  (por_pulse),
        .run  (cur_q.st == ST_PWRUP),
        .step (slow_tick),
        .done (pwr_done)
    );

    rts_timer #(.LIMIT(OST_CYCLES)) u_ost_timer (
        .clk  (clk_osc),
        .rst  (por_pulse),
        .run  (cur_q.st == ST_OSCST),
        .step (1'b1),
        .done (ost_done)
    );

    always_comb begin
        cur_d     = cur_q;
        finish_st = pin_ok ? ST_RUN : ST_PINHOLD;
        if (bor_evt) begin
            cur_d.st   = ST_IDLE;
            cur_d.kind = KIND_POWER;
        end else begin
            unique case (cur_q.st)
                ST_IDLE: begin
                    cur_d.xtal = mode_needs_ost(osc_mode);
                    if (cur_q.kind == KIND_POWER && pwrt_en) cur_d.st = ST_PWRUP;
                    else if (mode_needs_ost(osc_mode))       cur_d.st = ST_OSCST;
                    else                                     cur_d.st = finish_st;
                end
                ST_PWRUP: begin
                    if (pwr_done) cur_d.st = cur_q.xtal ? ST_OSCST : finish_st;
                end
                ST_OSCST: begin
                    if (ost_done) cur_d.st = finish_st;
                end
                ST_PINHOLD: begin
                    if (pin_ok) cur_d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (!pin_ok) begin
                        cur_d.st = ST_PINHOLD;
                    end else if (wake_evt) begin
                        cur_d.st   = ST_IDLE;
                        cur_d.kind = KIND_WAKE;
                    end
                end
                default: cur_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_osc or posedge por_pulse) begin
        if (por_pulse) begin
            cur_q.st   <= ST_IDLE;
            cur_q.kind <= KIND_POWER;
            cur_q.xtal <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign cfg_xtal  = cur_q.xtal;
    assign run_en    = (cur_q.st == ST_RUN);
    assign core_rst  = ~run_en;
    assign seq_state = cur_q.st;
endmodule

// File: rtl/rts_checker.sv
module rts_checker
    import rts_pkg::*;
(
    input logic       clk_osc,
    input logic       por_pulse,
    input logic       bor_evt,
    input logic       wake_evt,
    input logic       slow_tick,
    input logic       pin_ok,
    input logic       cfg_xtal,
    input logic       core_rst,
    input logic       run_en,
    input logic [2:0] seq_state
);
    AST_RUN_MATCHES_STATE: assert property (@(posedge clk_osc) disable iff (por_pulse)
        (run_en == (seq_state == ST_RUN)) && (core_rst == !run_en)); // R11

    AST_OST_ENTRY_PATH: assert property (@(posedge clk_osc) disable iff (por_pulse)
        (seq_state == ST_OSCST && $past(seq_state) != ST_OSCST)
        |-> ($past(seq_state) == ST_IDLE || $past(seq_state) == ST_PWRUP)); // R2

    AST_RC_SKIPS_OST: assert property (@(posedge clk_osc) disable iff (por_pulse)
        (seq_state == ST_OSCST) |-> cfg_xtal); // R4

    AST_PWRUP_NEEDS_TICK: assert property (@(posedge clk_osc) disable iff (por_pulse)
        (seq_state == ST_PWRUP && !slow_tick && !bor_evt) |=> seq_state == ST_PWRUP); // R5

    AST_BOR_TO_IDLE: assert property (@(posedge clk_osc) disable iff (por_pulse)
        bor_evt |=> seq_state == ST_IDLE); // R7

    AST_PIN_DROP_HOLDS: assert property (@(posedge clk_osc) disable iff (por_pulse)
        (seq_state == ST_RUN && !pin_ok && !bor_evt) |=> seq_state == ST_PINHOLD); // R10

    AST_WAKE_IGNORED: assert property (@(posedge clk_osc) disable iff (por_pulse)
        (wake_evt && !bor_evt && seq_state == ST_PWRUP && !slow_tick)
        |=> seq_state == ST_PWRUP); // R12
endmodule

bind rst_timeout_seq rts_checker u_chk (
    .clk_osc   (clk_osc),
    .por_pulse (por_pulse),
    .bor_evt   (bor_evt),
    .wake_evt  (wake_evt),
    .slow_tick (slow_tick),
    .pin_ok    (pin_ok),
    .cfg_xtal  (cfg_xtal),
    .core_rst  (core_rst),
    .run_en    (run_en),
    .seq_state (seq_state)
);

// File: tb/rst_timeout_seq_test.sv
module rst_timeout_seq_test;
    localparam int T = 40;
    localparam int C = 32;

    typedef struct packed {
        logic        wake;
        logic        pwrt;
        logic [1:0]  mode;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b1, 2'd1, 16'(1 + T + C)},
        '{1'b0, 1'b0, 2'd2, 16'(1 + C)},
        '{1'b0, 1'b1, 2'd0, 16'(1 + T + C)},
        '{1'b0, 1'b1, 2'd3, 16'(1 + T)},
        '{1'b0, 1'b0, 2'd3, 16'd3},
        '{1'b1, 1'b1, 2'd1, 16'(2 + C)},
        '{1'b1, 1'b1, 2'd3, 16'd2},
        '{1'b1, 1'b0, 2'd0, 16'(2 + C)}
    };

    logic       clk = 1'b0;
    logic       por = 1'b1, bor = 1'b0, wake = 1'b0, pin_n = 1'b1, tick = 1'b1, pwrt = 1'b1;
    logic [1:0] mode = 2'd1;
    logic       core_rst, run_en;
    logic [2:0] seq_state;
    int         checks = 0, fails = 0;

    always #2 clk = ~clk;

    rst_timeout_seq #(.PWRT_TICKS(T), .OST_CYCLES(C)) uut (
        .clk_osc(clk), .por_pulse(por), .bor_evt(bor), .wake_evt(wake),
        .ext_rst_n(pin_n), .slow_tick(tick), .osc_mode(mode), .pwrt_en(pwrt),
        .core_rst(core_rst), .run_en(run_en), .seq_state(seq_state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic power_up(input logic [1:0] m, input logic p);
        @(negedge clk);
        por = 1'b1; mode = m; pwrt = p; bor = 1'b0; wake = 1'b0;
        @(negedge clk);
        @(negedge clk);
        por = 1'b0;
    endtask

    task automatic edges_to_run(input int limit, output int n);
        bit seen = 1'b0;
        n = 0;
        while (!seen && n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (run_en) seen = 1'b1;
        end
    endtask

    task automatic step_edges(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        fails++; checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int tot;
        string tag;

        // R1: reset state while the pulse is held
        @(negedge clk);
        check(core_rst == 1'b1 && run_en == 1'b0, "R1 outputs", {core_rst, run_en}, 2);
        check(seq_state == 3'd0, "R1 state", seq_state, 0);

        // table of power-on and wake cases
        for (int i = 0; i < 8; i++) begin
            if (VEC[i].wake) tag = "R6";
            else if (VEC[i].mode == 2'd3) tag = "R4";
            else if (VEC[i].pwrt) tag = "R2";
            else tag = "R3";
            tick = 1'b1;
            power_up(VEC[i].mode, VEC[i].pwrt);
            edges_to_run(500, n);
            if (VEC[i].wake) begin
                wake = 1'b1;
                @(negedge clk);
                wake = 1'b0;
                edges_to_run(500, n);
                tot = n + 1;
            end else begin
                tot = n;
            end
            check(tot == int'(VEC[i].exp), tag, tot, int'(VEC[i].exp));
            check(core_rst == !run_en, "R11", core_rst, !run_en);
        end

        // R5: no tick, no progress
        tick = 1'b0;
        power_up(2'd1, 1'b1);
        step_edges(100);
        check(seq_state == 3'd1, "R5 stalled", seq_state, 1);
        tick = 1'b1;
        edges_to_run(500, n);
        check(n == T + C, "R5 resume", n, T + C);

        // R8: configuration change after start is ignored
        power_up(2'd1, 1'b1);
        step_edges(5);
        mode = 2'd3; pwrt = 1'b0;
        edges_to_run(500, n);
        check(n + 5 == 1 + T + C, "R8", n + 5, 1 + T + C);

        // R12: wake outside running is ignored
        power_up(2'd1, 1'b1);
        step_edges(3);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        edges_to_run(500, n);
        check(n + 4 == 1 + T + C, "R12", n + 4, 1 + T + C);

        // R7: brown-out from running restarts the whole sequence
        bor = 1'b1;
        @(negedge clk);
        bor = 1'b0;
        check(seq_state == 3'd0, "R7 idle", seq_state, 0);
        edges_to_run(500, n);
        check(n + 1 == 2 + T + C, "R7 timing", n + 1, 2 + T + C);

        // R10: pin drop while running, no time-out on release
        pin_n = 1'b0;
        step_edges(2);
        check(run_en == 1'b1, "R10 not yet", run_en, 1);
        step_edges(1);
        check(core_rst == 1'b1 && seq_state == 3'd3, "R10 hold", seq_state, 3);
        pin_n = 1'b1;
        edges_to_run(500, n);
        check(n == 3, "R10 release", n, 3);

        // R9: pin held past both timers
        pin_n = 1'b0;
        power_up(2'd1, 1'b1);
        step_edges(T + C + 20);
        check(seq_state == 3'd3 && core_rst == 1'b1, "R9 hold", seq_state, 3);
        pin_n = 1'b1;
        step_edges(2);
        check(run_en == 1'b0, "R9 early", run_en, 0);
        step_edges(1);
        check(run_en == 1'b1, "R9 release", run_en, 1);
        check(seq_state == 3'd4, "R11 state", seq_state, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule